// File: doc/BRIEF.md
# Automatic serial flow controller

This block handles flow control for one asynchronous serial channel. It sits between the receive shift register, the receive queue and the transmit serialiser, and it never touches the serial lines itself. On the transmit side it produces one enable. The serialiser may start a new data character only while that enable is high, and the enable changes only between characters. Three things can pull it low: the remote clear-to-send input (when auto-CTS is on), a received Xoff (when software flow control is on), and a flow character that is waiting to be sent.

On the receive side every received character passes through the block on its way to the queue. Flow characters are removed from the stream. Xoff and Xon can be matched as single characters or as two-character pairs. An any-character mode lets any received character end a suspension. A special-character mode flags matches against the fourth flow register and keeps them in the data stream. From the queue fill level the block drives RTS, with hysteresis between the trigger levels on either side of the programmed one. It can also ask the serialiser to send Xoff or Xon characters as the fill crosses the programmed trigger level.

Received characters must arrive at least two clock cycles apart. A held first character of a pair can then be released, together with the character that broke the pair, without colliding with the next arrival. The mode bits are expected to change only while the line is idle.

Top module: `serial_flow_ctrl`

## Requirements
- R1: After reset, tx_en_o is 1 and rts_o, ins_req_o, rx_wr_o, rx_drop_o, special_hit_o and xoff_active_o are 0.
- R2: The four flow registers reset to 0x00. A write with cfg_we_i loads cfg_data_i into the register chosen by cfg_sel_i (0 = Xon first, 1 = Xon second, 2 = Xoff first, 3 = Xoff second). When a character matches both the Xon and the Xoff value, Xoff wins.
- R3: With auto_cts_en_i set, cts_i at 1 makes tx_en_o go to 0 one cycle later, but only in a cycle where tx_busy_i is 0. tx_en_o never changes in the cycle after a cycle with tx_busy_i at 1. When cts_i returns to 0, tx_en_o returns to 1. With auto_cts_en_i clear, cts_i has no effect.
- R4: With auto_rts_en_i set, rts_o goes to 1 one cycle after rx_fill_i >= trig_hi_i. It goes back to 0 one cycle after rx_fill_i <= trig_lo_i, and holds its value in between. With auto_rts_en_i clear, rts_o is 0.
- R5: Single-character software mode (sw_rx_en_i=1, sw_dual_i=0). A character that matches Xoff-first sets xoff_active_o, and tx_en_o then falls at the next character boundary. A character that matches Xon-first clears xoff_active_o. Neither character is written. Instead, rx_drop_o pulses one cycle after rx_valid_i.
- R6: Double-character mode (sw_dual_i=1). Xoff-first followed by Xoff-second suspends, and Xon-first followed by Xon-second resumes. Neither character of a completed pair is written. When the pair breaks, the held first character is written and then the breaking character, in arrival order (one and two cycles after the second arrival).
- R7: With any_resume_i set, any received character that is not an Xoff match clears xoff_active_o. That character is still written.
- R8: Matching compares only the low 5, 6, 7 or 8 bits, chosen by word_len_i = 0, 1, 2 or 3. Bit 0 is the first serial bit.
- R9: With special_mode_i set, every character is written. A character that matches Xoff-second pulses special_hit_o alongside its write. Xon/Xoff suspension is forced off and nothing is dropped.
- R10: With sw_tx_en_i set, a rise of rx_fill_i to trig_prog_i or above raises ins_req_o with the Xoff-first character, once per crossing. A fall below trig_prog_i after that raises ins_req_o with the Xon-first character. Each request ends on ins_ack_i.
- R11: In double mode the second character of the pair is requested in the cycle after the first ack. tx_en_o stays 0 from the cycle after a request appears at a character boundary until the sequence ends, so no data byte splits the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Flow register write strobe |
| cfg_sel_i | input | 2 | Flow register select (0 Xon1, 1 Xon2, 2 Xoff1, 3 Xoff2) |
| cfg_data_i | input | 8 | Flow register write data |
| auto_cts_en_i | input | 1 | Enable transmit gating from CTS |
| auto_rts_en_i | input | 1 | Enable RTS from fill level |
| sw_rx_en_i | input | 1 | Enable Xon/Xoff detection on receive |
| sw_tx_en_i | input | 1 | Enable Xon/Xoff insertion on transmit |
| sw_dual_i | input | 1 | Two-character Xon/Xoff pairs |
| any_resume_i | input | 1 | Any received character resumes |
| special_mode_i | input | 1 | Special-character detect mode |
| word_len_i | input | 2 | Character length 5/6/7/8 bits |
| cts_i | input | 1 | Remote clear-to-send, 1 = stop |
| tx_busy_i | input | 1 | Serialiser is inside a character |
| rx_valid_i | input | 1 | Received character strobe |
| rx_char_i | input | 8 | Received character |
| rx_fill_i | input | FILL_W | Receive queue fill count |
| trig_lo_i | input | FILL_W | Trigger level below the programmed one |
| trig_prog_i | input | FILL_W | Programmed trigger level |
| trig_hi_i | input | FILL_W | Trigger level above the programmed one |
| ins_ack_i | input | 1 | Serialiser took the requested flow character |
| tx_en_o | output | 1 | Serialiser may start a data character |
| rts_o | output | 1 | Request-to-send, 1 = stop |
| ins_req_o | output | 1 | Flow character waiting to be sent |
| ins_char_o | output | 8 | Flow character to send |
| rx_wr_o | output | 1 | Write strobe to the receive queue |
| rx_wr_data_o | output | 8 | Character to write |
| rx_drop_o | output | 1 | A flow character was removed |
| special_hit_o | output | 1 | Special character seen |
| xoff_active_o | output | 1 | Suspended by a received Xoff |

## Verification
The bench raises CTS while a character is in flight. A design that gates mid-character would drop tx_en_o before the boundary. It broken Xoff pair. A design that dropped the held first character, or wrote the two characters in the wrong order, shows a wrong queue log. It walks the fill level through the hysteresis band. An RTS that follows only the programmed level would toggle inside the band. It also checks that 5-bit matching ignores the upper bits, that an unwritten flow register matches 0x00 with Xoff taking priority, and that the second character of an inserted pair follows straight after the first while data stays blocked.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int CHAR_W  = 8;
  localparam int NUM_FC  = 4;
  localparam int SEL_W   = $clog2(NUM_FC);
  localparam int IDX_XON1  = 0;
  localparam int IDX_XON2  = 1;
  localparam int IDX_XOFF1 = 2;
  localparam int IDX_XOFF2 = 3;

  typedef enum logic [1:0] {INS_IDLE, INS_FIRST, INS_SECOND} ins_state_e;

  // word length code 0..3 -> 5..8 valid low bits
  function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] wl);
    return {CHAR_W{1'b1}} >> (2'd3 - wl);
  endfunction
endpackage

// File: rtl/fc_rts_hyst.sv
module fc_rts_hyst #(
  parameter int FILL_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic [FILL_W-1:0] lo_i,
  input  logic [FILL_W-1:0] hi_i,
  output logic              rts_o
);
  logic rts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rts_q <= 1'b0;
    else if (!en_i)           rts_q <= 1'b0;
    else if (fill_i >= hi_i)  rts_q <= 1'b1;
    else if (fill_i <= lo_i)  rts_q <= 1'b0;
  end

  assign rts_o = rts_q;
endmodule

// File: rtl/fc_tx_insert.sv
module fc_tx_insert
  import flow_pkg::*;
#(
  parameter int FILL_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              dual_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic [FILL_W-1:0] prog_i,
  input  logic [CHAR_W-1:0] xon1_i,
  input  logic [CHAR_W-1:0] xon2_i,
  input  logic [CHAR_W-1:0] xoff1_i,
  input  logic [CHAR_W-1:0] xoff2_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              hold_o
);
  ins_state_e state_q, state_d;
  logic kind_q, kind_d;   // 1 = Xon sequence
  logic sent_q, sent_d;   // Xoff sent, Xon owed
  logic start_off, start_on;

  assign start_off = en_i && !sent_q && (fill_i >= prog_i);
  assign start_on  = en_i &&  sent_q && (fill_i <  prog_i);

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    sent_d  = sent_q;
    unique case (state_q)
      INS_IDLE: begin
        if (!en_i) sent_d = 1'b0;
        else if (start_off) begin
          state_d = INS_FIRST; kind_d = 1'b0; sent_d = 1'b1;
        end else if (start_on) begin
          state_d = INS_FIRST; kind_d = 1'b1; sent_d = 1'b0;
        end
      end
      INS_FIRST:  if (ack_i) state_d = dual_i ? INS_SECOND : INS_IDLE;
      INS_SECOND: if (ack_i) state_d = INS_IDLE;
      default:    state_d = INS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= INS_IDLE;
      kind_q  <= 1'b0;
      sent_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      sent_q  <= sent_d;
    end
  end

  assign req_o  = (state_q != INS_IDLE);
  assign hold_o = req_o || start_off || start_on;

  always_comb begin
    if (state_q == INS_SECOND) char_o = kind_q ? xon2_i : xoff2_i;
    else                       char_o = kind_q ? xon1_i : xoff1_i;
  end
endmodule

// File: rtl/fc_rx_match.sv
module fc_rx_match
  import flow_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_en_i,
  input  logic              dual_i,
  input  logic              any_resume_i,
  input  logic              special_i,
  input  logic [1:0]        word_len_i,
  input  logic [CHAR_W-1:0] xon1_i,
  input  logic [CHAR_W-1:0] xon2_i,
  input  logic [CHAR_W-1:0] xoff1_i,
  input  logic [CHAR_W-1:0] xoff2_i,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_char_i,
  output logic              wr_o,
  output logic [CHAR_W-1:0] wr_data_o,
  output logic              drop_o,
  output logic              special_hit_o,
  output logic              xoff_active_o
);
  logic [CHAR_W-1:0] mask, c_m;
  logic hit_xon1, hit_xon2, hit_xoff1, hit_xoff2;

  assign mask      = len_mask(word_len_i);
  assign c_m       = rx_char_i & mask;
  assign hit_xon1  = (c_m == (xon1_i  & mask));
  assign hit_xon2  = (c_m == (xon2_i  & mask));
  assign hit_xoff1 = (c_m == (xoff1_i & mask));
  assign hit_xoff2 = (c_m == (xoff2_i & mask));

  // pending first-of-pair, late (second) write slot, registered outputs
  logic              pend_q, pend_d, kind_q, kind_d;
  logic [CHAR_W-1:0] pdat_q, pdat_d;
  logic              late_v_q, late_v_d;
  logic [CHAR_W-1:0] late_d_q, late_d_d;
  logic              out_v_q, out_v_d;
  logic [CHAR_W-1:0] out_d_q, out_d_d;
  logic              drop_q, drop_d, spec_q, spec_d, xoff_q, xoff_d;

  always_comb begin
    pend_d   = pend_q;  kind_d = kind_q;  pdat_d = pdat_q;
    late_v_d = 1'b0;    late_d_d = late_d_q;
    out_v_d  = late_v_q; out_d_d = late_d_q;
    drop_d   = 1'b0;    spec_d = 1'b0;    xoff_d = xoff_q;

    if (!sw_en_i || special_i) begin
      pend_d = 1'b0;
      xoff_d = 1'b0;
    end

    if (rx_valid_i) begin
      if (special_i) begin
        out_v_d = 1'b1; out_d_d = rx_char_i; spec_d = hit_xoff2;
      end else if (!sw_en_i) begin
        out_v_d = 1'b1; out_d_d = rx_char_i;
      end else if (!dual_i) begin
        if (hit_xoff1) begin
          xoff_d = 1'b1; drop_d = 1'b1;
        end else if (hit_xon1) begin
          xoff_d = 1'b0; drop_d = 1'b1;
        end else begin
          out_v_d = 1'b1; out_d_d = rx_char_i;
          if (any_resume_i) xoff_d = 1'b0;
        end
      end else begin
        if (pend_q && !kind_q && hit_xoff2) begin
          xoff_d = 1'b1; drop_d = 1'b1; pend_d = 1'b0;
        end else if (pend_q && kind_q && hit_xon2) begin
          xoff_d = 1'b0; drop_d = 1'b1; pend_d = 1'b0;
        end else begin
          if (any_resume_i) xoff_d = 1'b0;
          if (pend_q) begin
            out_v_d = 1'b1; out_d_d = pdat_q;
          end
          if (hit_xoff1 || hit_xon1) begin
            pend_d = 1'b1; kind_d = !hit_xoff1; pdat_d = rx_char_i;
          end else begin
            pend_d = 1'b0;
            if (pend_q) begin
              late_v_d = 1'b1; late_d_d = rx_char_i;
            end else begin
              out_v_d = 1'b1; out_d_d = rx_char_i;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0; kind_q <= 1'b0; pdat_q <= '0;
      late_v_q <= 1'b0; late_d_q <= '0;
      out_v_q <= 1'b0; out_d_q <= '0;
      drop_q <= 1'b0; spec_q <= 1'b0; xoff_q <= 1'b0;
    end else begin
      pend_q <= pend_d; kind_q <= kind_d; pdat_q <= pdat_d;
      late_v_q <= late_v_d; late_d_q <= late_d_d;
      out_v_q <= out_v_d; out_d_q <= out_d_d;
      drop_q <= drop_d; spec_q <= spec_d; xoff_q <= xoff_d;
    end
  end

  assign wr_o          = out_v_q;
  assign wr_data_o     = out_d_q;
  assign drop_o        = drop_q;
  assign special_hit_o = spec_q;
  assign xoff_active_o = xoff_q;
endmodule

// File: rtl/serial_flow_ctrl.sv
module serial_flow_ctrl
  import flow_pkg::*;
#(
  parameter int FILL_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [7:0]        cfg_data_i,
  input  logic              auto_cts_en_i,
  input  logic              auto_rts_en_i,
  input  logic              sw_rx_en_i,
  input  logic              sw_tx_en_i,
  input  logic              sw_dual_i,
  input  logic              any_resume_i,
  input  logic              special_mode_i,
  input  logic [1:0]        word_len_i,
  input  logic              cts_i,
  input  logic              tx_busy_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_char_i,
  input  logic [FILL_W-1:0] rx_fill_i,
  input  logic [FILL_W-1:0] trig_lo_i,
  input  logic [FILL_W-1:0] trig_prog_i,
  input  logic [FILL_W-1:0] trig_hi_i,
  input  logic              ins_ack_i,
  output logic              tx_en_o,
  output logic              rts_o,
  output logic              ins_req_o,
  output logic [7:0]        ins_char_o,
  output logic              rx_wr_o,
  output logic [7:0]        rx_wr_data_o,
  output logic              rx_drop_o,
  output logic              special_hit_o,
  output logic              xoff_active_o
);
  logic [CHAR_W-1:0] fc_q [NUM_FC];

  for (genvar g = 0; g < NUM_FC; g++) begin : g_fc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fc_q[g] <= '0;
      else if (cfg_we_i && (cfg_sel_i == SEL_W'(g))) fc_q[g] <= cfg_data_i;
    end
  end

  fc_rx_match u_rx (
    .clk_i, .rst_ni,
    .sw_en_i       (sw_rx_en_i),
    .dual_i        (sw_dual_i),
    .any_resume_i  (any_resume_i),
    .special_i     (special_mode_i),
    .word_len_i    (word_len_i),
    .xon1_i        (fc_q[IDX_XON1]),
    .xon2_i        (fc_q[IDX_XON2]),
    .xoff1_i       (fc_q[IDX_XOFF1]),
    .xoff2_i       (fc_q[IDX_XOFF2]),
    .rx_valid_i    (rx_valid_i),
    .rx_char_i     (rx_char_i),
    .wr_o          (rx_wr_o),
    .wr_data_o     (rx_wr_data_o),
    .drop_o        (rx_drop_o),
    .special_hit_o (special_hit_o),
    .xoff_active_o (xoff_active_o)
  );

  fc_rts_hyst #(.FILL_W(FILL_W)) u_rts (
    .clk_i, .rst_ni,
    .en_i   (auto_rts_en_i),
    .fill_i (rx_fill_i),
    .lo_i   (trig_lo_i),
    .hi_i   (trig_hi_i),
    .rts_o  (rts_o)
  );

  logic ins_hold;

  fc_tx_insert #(.FILL_W(FILL_W)) u_ins (
    .clk_i, .rst_ni,
    .en_i    (sw_tx_en_i),
    .dual_i  (sw_dual_i),
    .fill_i  (rx_fill_i),
    .prog_i  (trig_prog_i),
    .xon1_i  (fc_q[IDX_XON1]),
    .xon2_i  (fc_q[IDX_XON2]),
    .xoff1_i (fc_q[IDX_XOFF1]),
    .xoff2_i (fc_q[IDX_XOFF2]),
    .ack_i   (ins_ack_i),
    .req_o   (ins_req_o),
    .char_o  (ins_char_o),
    .hold_o  (ins_hold)
  );

  // data-start gate, only re-evaluated between characters
  logic tx_en_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_en_q <= 1'b1;
    else if (!tx_busy_i)
      tx_en_q <= !(auto_cts_en_i && cts_i) && !xoff_active_o && !ins_hold;
  end
  assign tx_en_o = tx_en_q;
endmodule

// File: rtl/serial_flow_ctrl_chk.sv
module serial_flow_ctrl_chk #(
  parameter int FILL_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_busy_i,
  input logic              auto_cts_en_i,
  input logic              cts_i,
  input logic              auto_rts_en_i,
  input logic [FILL_W-1:0] rx_fill_i,
  input logic [FILL_W-1:0] trig_lo_i,
  input logic [FILL_W-1:0] trig_hi_i,
  input logic              special_mode_i,
  input logic              tx_en_o,
  input logic              rts_o,
  input logic              ins_req_o,
  input logic              rx_drop_o,
  input logic              xoff_active_o
);
  // R3
  en_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_i |=> $stable(tx_en_o));
  // R3
  cts_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_busy_i && auto_cts_en_i && cts_i) |=> !tx_en_o);
  // R4
  rts_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_rts_en_i && rx_fill_i >= trig_hi_i) |=> rts_o);
  // R4
  rts_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_rts_en_i && trig_lo_i < trig_hi_i && rx_fill_i <= trig_lo_i) |=> !rts_o);
  // R4
  rts_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_rts_en_i |=> !rts_o);
  // R11
  ins_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_req_o && !tx_busy_i) |=> !tx_en_o);
  // R9
  special_nodrop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    special_mode_i |=> !rx_drop_o);
  // R9
  special_noxoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (special_mode_i && $past(special_mode_i)) |-> !xoff_active_o);
endmodule

bind serial_flow_ctrl serial_flow_ctrl_chk #(.FILL_W(FILL_W)) u_chk (.*);

// File: tb/tb_serial_flow_ctrl.sv
`timescale 1ns/1ps
module tb_serial_flow_ctrl;
  localparam int FILL_W = 7;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_ni, cfg_we, auto_cts, auto_rts, sw_rx, sw_tx, dual, any_res, special;
  logic [1:0]        cfg_sel, wl;
  logic [7:0]        cfg_data, rx_char;
  logic              cts, busy, rx_valid, ack;
  logic [FILL_W-1:0] fill, t_lo, t_prog, t_hi;
  logic              tx_en, rts, ins_req, rx_wr, rx_drop, spec_hit, xoff_act;
  logic [7:0]        ins_char, rx_wr_data;

  serial_flow_ctrl #(.FILL_W(FILL_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .auto_cts_en_i(auto_cts), .auto_rts_en_i(auto_rts), .sw_rx_en_i(sw_rx), .sw_tx_en_i(sw_tx),
    .sw_dual_i(dual), .any_resume_i(any_res), .special_mode_i(special), .word_len_i(wl),
    .cts_i(cts), .tx_busy_i(busy), .rx_valid_i(rx_valid), .rx_char_i(rx_char),
    .rx_fill_i(fill), .trig_lo_i(t_lo), .trig_prog_i(t_prog), .trig_hi_i(t_hi),
    .ins_ack_i(ack), .tx_en_o(tx_en), .rts_o(rts), .ins_req_o(ins_req), .ins_char_o(ins_char),
    .rx_wr_o(rx_wr), .rx_wr_data_o(rx_wr_data), .rx_drop_o(rx_drop),
    .special_hit_o(spec_hit), .xoff_active_o(xoff_act)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] wlog [16];
  int n_wr = 0, n_drop = 0, n_spec = 0;

  always @(negedge clk) begin
    if (rx_wr) begin
      if (n_wr < 16) wlog[n_wr] = rx_wr_data;
      n_wr++;
    end
    if (rx_drop)  n_drop++;
    if (spec_hit) n_spec++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 0; cfg_we = 0; cfg_sel = 0; cfg_data = 0;
    auto_cts = 0; auto_rts = 0; sw_rx = 0; sw_tx = 0; dual = 0; any_res = 0; special = 0;
    wl = 2'd3; cts = 0; busy = 0; rx_valid = 0; rx_char = 0; ack = 0;
    fill = 0; t_lo = 8; t_prog = 16; t_hi = 24;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    n_wr = 0; n_drop = 0; n_spec = 0;
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_data = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic load_chars();
    wr_reg(2'd0, 8'h11); wr_reg(2'd1, 8'h12); wr_reg(2'd2, 8'h13); wr_reg(2'd3, 8'h14);
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk); rx_valid = 1; rx_char = c;
    @(negedge clk); rx_valid = 0;
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 tx_en", tx_en, 1);
    chk("R1 rts", rts, 0);
    chk("R1 ins_req", ins_req, 0);
    chk("R1 rx_wr", rx_wr, 0);
    chk("R1 xoff_active", xoff_act, 0);
  endtask

  task automatic t_reg_default();
    do_reset();
    sw_rx = 1;
    send(8'h00);
    chk("R2 zero regs drop", n_drop, 1);
    chk("R2 Xoff priority", xoff_act, 1);
    chk("R2 no write", n_wr, 0);
    wr_reg(2'd2, 8'h13);
    send(8'h00);
    chk("R2 Xon still zero resumes", xoff_act, 0);
    chk("R2 second drop", n_drop, 2);
  endtask

  task automatic t_cts();
    do_reset();
    cts = 1;
    repeat (2) @(negedge clk);
    chk("R3 cts ignored when off", tx_en, 1);
    auto_cts = 1; busy = 1;
    repeat (3) @(negedge clk);
    chk("R3 hold mid-character", tx_en, 1);
    busy = 0;
    @(negedge clk);
    chk("R3 halt at boundary", tx_en, 0);
    cts = 0;
    @(negedge clk);
    chk("R3 resume", tx_en, 1);
  endtask

  task automatic t_rts();
    do_reset();
    fill = 30;
    @(negedge clk);
    chk("R4 disabled", rts, 0);
    auto_rts = 1; fill = 20;
    @(negedge clk); chk("R4 below hi", rts, 0);
    fill = 24; @(negedge clk); chk("R4 at hi", rts, 1);
    fill = 16; @(negedge clk); chk("R4 hold in band", rts, 1);
    fill = 9;  @(negedge clk); chk("R4 hold above lo", rts, 1);
    fill = 8;  @(negedge clk); chk("R4 at lo", rts, 0);
    fill = 20; @(negedge clk); chk("R4 stays low in band", rts, 0);
  endtask

  task automatic t_single();
    do_reset(); load_chars(); sw_rx = 1;
    send(8'h41);
    chk("R5 data written", n_wr, 1);
    chk("R5 data value", wlog[0], 8'h41);
    send(8'h13);
    chk("R5 Xoff sets", xoff_act, 1);
    chk("R5 Xoff gates tx", tx_en, 0);
    chk("R5 Xoff dropped", n_drop, 1);
    send(8'h11);
    chk("R5 Xon clears", xoff_act, 0);
    chk("R5 Xon tx back", tx_en, 1);
    chk("R5 no extra writes", n_wr, 1);
  endtask

  task automatic t_dual();
    do_reset(); load_chars(); sw_rx = 1; dual = 1;
    send(8'h13); send(8'h14);
    chk("R6 pair suspends", xoff_act, 1);
    chk("R6 pair not written", n_wr, 0);
    send(8'h11); send(8'h12);
    chk("R6 pair resumes", xoff_act, 0);
    chk("R6 drops", n_drop, 2);
    send(8'h13); send(8'h41);
    chk("R6 broken pair count", n_wr, 2);
    chk("R6 held first", wlog[0], 8'h13);
    chk("R6 breaker second", wlog[1], 8'h41);
    send(8'h13); send(8'h11); send(8'h12);
    chk("R6 re-arm on Xon1", n_wr, 3);
    chk("R6 re-armed value", wlog[2], 8'h13);
  endtask

  task automatic t_wordlen();
    do_reset(); load_chars(); sw_rx = 1;
    send(8'hF3);
    chk("R8 8-bit no match", n_wr, 1);
    chk("R8 8-bit no xoff", xoff_act, 0);
    wl = 2'd0;
    send(8'hF3);
    chk("R8 5-bit match", xoff_act, 1);
    chk("R8 5-bit dropped", n_drop, 1);
  endtask

  task automatic t_any();
    do_reset(); load_chars(); sw_rx = 1; any_res = 1;
    send(8'h13);
    chk("R7 suspended", xoff_act, 1);
    send(8'h55);
    chk("R7 any char resumes", xoff_act, 0);
    chk("R7 char kept", wlog[0], 8'h55);
  endtask

  task automatic t_special();
    do_reset(); load_chars(); special = 1; sw_rx = 1;
    send(8'h14);
    chk("R9 match written", n_wr, 1);
    chk("R9 flag pulse", n_spec, 1);
    send(8'h13);
    chk("R9 Xoff not acted", xoff_act, 0);
    chk("R9 no drop", n_drop, 0);
    chk("R9 no flag on other", n_spec, 1);
  endtask

  task automatic t_ins_single();
    do_reset(); load_chars(); sw_tx = 1;
    @(negedge clk);
    chk("R10 idle", ins_req, 0);
    fill = 16; @(negedge clk);
    chk("R10 Xoff request", ins_req, 1);
    chk("R10 Xoff char", ins_char, 8'h13);
    pulse_ack();
    chk("R10 ack ends", ins_req, 0);
    fill = 20; @(negedge clk);
    chk("R10 once per crossing", ins_req, 0);
    fill = 15; @(negedge clk);
    chk("R10 Xon request", ins_req, 1);
    chk("R10 Xon char", ins_char, 8'h11);
    pulse_ack();
    chk("R10 Xon ends", ins_req, 0);
  endtask

  task automatic t_ins_dual();
    do_reset(); load_chars(); sw_tx = 1; dual = 1;
    fill = 16; @(negedge clk);
    chk("R11 first char", ins_char, 8'h13);
    chk("R11 data blocked", tx_en, 0);
    pulse_ack();
    chk("R11 second pending", ins_req, 1);
    chk("R11 second char", ins_char, 8'h14);
    chk("R11 still blocked", tx_en, 0);
    pulse_ack();
    chk("R11 done", ins_req, 0);
    @(negedge clk);
    chk("R11 data released", tx_en, 1);
  endtask

  initial begin
    t_reset_state();
    t_reg_default();
    t_cts();
    t_rts();
    t_single();
    t_dual();
    t_wordlen();
    t_any();
    t_special();
    t_ins_single();
    t_ins_dual();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule